// File: doc/BRIEF.md
# Endpoint Interrupt Aggregation Tree

This block combines endpoint events from a USB device controller into one interrupt line. It serves NUM_EP IN endpoints and NUM_EP OUT endpoints, 16 of each by default. The interrupt passes through three levels. At the first level, each endpoint has an 8-bit status vector. A one-cycle event pulse from the protocol core sets a status bit, and software clears it by writing 1 to that bit. At the second level, each endpoint gets a summary bit, which is the OR of its status bits after a shared enable mask is applied. The IN endpoints share one enable mask and the OUT endpoints share another. All summary bits are collected in a 32-bit read-only endpoint register. At the third level, a per-endpoint enable mask gates the summaries into an IN core bit and an OUT core bit. A registered interrupt output is the OR of those two core bits.

Software receives the interrupt and reads the endpoint register to find which endpoint needs service. It then reads that endpoint's status and writes 1s back to clear the bits it has handled. The per-endpoint mask hides an endpoint from the interrupt only. The endpoint's summary bit stays visible in the endpoint register. Because every level above the status bits is a pure function of them, clearing a status bit clears each level above it with no further action.

The register port uses word addresses. A write takes effect at the clock edge. The read data is combinational from the address.

Top module: `epIrqAgg`

## Requirements
- R1: After reset all status vectors, both shared masks and the per-endpoint mask are 0 (everything disabled). Every register reads 0, and `inIrq`, `outIrq` and `intOut` are low.
- R2: An event pulse on bit b of `inEvt[n*8 +: 8]` (or `outEvt[n*8 +: 8]`) sets status bit b of IN (OUT) endpoint n at the next clock edge. The IN status of endpoint n reads at address 0x10+n and the OUT status at 0x20+n.
- R3: A write to a status address clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: An endpoint's summary bit is the OR of its status bits ANDed with the shared mask for its direction, where 1 enables. The IN mask is at address 0x00 and the OUT mask at 0x01. The same mask applies to every endpoint of that direction.
- R6: The endpoint register at address 0x02 holds the IN summary of endpoint n at bit n and the OUT summary at bit 16+n. An endpoint with both IN and OUT events shows both bits. Writes to this address are ignored.
- R7: The per-endpoint mask at address 0x03 uses the same bit layout as the endpoint register. A masked endpoint still shows its summary bit in the endpoint register but does not reach the core bits.
- R8: `inIrq` is the OR of the enabled IN summary bits and `outIrq` is the OR of the enabled OUT summary bits. Address 0x04 reads `inIrq` at bit 0 and `outIrq` at bit 1.
- R9: `intOut` equals the OR of `inIrq` and `outIrq` one clock later.
- R10: Clearing the last enabled status bit of an endpoint drops its endpoint register bit and the core bit in the same cycle, and drops `intOut` one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inEvt | input | NUM_EP*STAT_W | IN event pulses, endpoint n at bits n*STAT_W +: STAT_W |
| outEvt | input | NUM_EP*STAT_W | OUT event pulses, same layout |
| regAddr | input | ADDR_W | Register word address |
| regWrEn | input | 1 | Write strobe for regWrData at regAddr |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at regAddr |
| inIrq | output | 1 | IN core-level summary |
| outIrq | output | 1 | OUT core-level summary |
| intOut | output | 1 | Registered interrupt line, level-sensitive |

## Verification
The hardest case to reach from the ports is a status bit that receives a new event pulse in the same cycle that software clears it. A dedicated driver task therefore drives an event vector and a write-1 clear on the same endpoint in one cycle, and then reads the status back.

A second hard case is an endpoint that is hidden from the interrupt while it is still visible in the endpoint register. The stimulus reaches it by enabling the status masks while leaving the endpoint's per-endpoint mask at 0. It then checks the endpoint register, the core bits and the delayed interrupt line separately.

// File: rtl/epIrqPkg.sv
package epIrqPkg;

  // read-side source selection produced by the decoder
  typedef enum logic [2:0] {
    RD_NONE,
    RD_IN_MSK,
    RD_OUT_MSK,
    RD_ALL_EP,
    RD_EP_MSK,
    RD_CORE,
    RD_IN_ST,
    RD_OUT_ST
  } rdSelT;

  typedef struct packed {
    logic  wrInMsk;
    logic  wrOutMsk;
    logic  wrEpMsk;
    logic  clrInSt;
    logic  clrOutSt;
    rdSelT rdSel;
  } ctrlStrobeT;

  // address regions (upper address bits) and offsets in the global region
  localparam logic [1:0] REG_GLOBAL = 2'd0;
  localparam logic [1:0] REG_IN_ST  = 2'd1;
  localparam logic [1:0] REG_OUT_ST = 2'd2;

  localparam logic [3:0] OFS_IN_MSK  = 4'h0;
  localparam logic [3:0] OFS_OUT_MSK = 4'h1;
  localparam logic [3:0] OFS_ALL_EP  = 4'h2;
  localparam logic [3:0] OFS_EP_MSK  = 4'h3;
  localparam logic [3:0] OFS_CORE    = 4'h4;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OUT_BASE = 16;

endpackage

// File: rtl/epIrqCtrl.sv
module epIrqCtrl
  import epIrqPkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobeT        strb,
  output logic [EP_W-1:0]   epSel
);

  logic [ADDR_W-5:0] region;
  logic [3:0]        offset;
  logic              epValid;

  assign region  = regAddr[ADDR_W-1:4];
  assign offset  = regAddr[3:0];
  assign epValid = ({1'b0, offset} < 5'(NUM_EP));
  assign epSel   = offset[EP_W-1:0];

  always_comb begin
    strb = '{wrInMsk: 1'b0, wrOutMsk: 1'b0, wrEpMsk: 1'b0,
             clrInSt: 1'b0, clrOutSt: 1'b0, rdSel: RD_NONE};
    if (region == (ADDR_W-4)'(REG_GLOBAL)) begin
      case (offset)
        OFS_IN_MSK:  begin strb.wrInMsk  = regWrEn; strb.rdSel = RD_IN_MSK;  end
        OFS_OUT_MSK: begin strb.wrOutMsk = regWrEn; strb.rdSel = RD_OUT_MSK; end
        OFS_ALL_EP:  strb.rdSel = RD_ALL_EP;
        OFS_EP_MSK:  begin strb.wrEpMsk  = regWrEn; strb.rdSel = RD_EP_MSK;  end
        OFS_CORE:    strb.rdSel = RD_CORE;
        default:     strb.rdSel = RD_NONE;
      endcase
    end else if (region == (ADDR_W-4)'(REG_IN_ST) && epValid) begin
      strb.clrInSt = regWrEn;
      strb.rdSel   = RD_IN_ST;
    end else if (region == (ADDR_W-4)'(REG_OUT_ST) && epValid) begin
      strb.clrOutSt = regWrEn;
      strb.rdSel    = RD_OUT_ST;
    end
  end

endmodule

// File: rtl/epIrqData.sv
module epIrqData
  import epIrqPkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned STAT_W = 8,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobeT               strb,
  input  logic [EP_W-1:0]          epSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_EP*STAT_W-1:0] inEvt,
  input  logic [NUM_EP*STAT_W-1:0] outEvt,
  output logic [DATA_W-1:0]        rdData,
  output logic [DATA_W-1:0]        allEp,
  output logic                     inCore,
  output logic                     outCore,
  output logic                     intOut
);

  logic [STAT_W-1:0] inSt  [NUM_EP];
  logic [STAT_W-1:0] outSt [NUM_EP];
  logic [STAT_W-1:0] inMsk, outMsk;
  logic [DATA_W-1:0] epMsk;
  logic [NUM_EP-1:0] inEpSum, outEpSum;

  // shared masks and per-endpoint mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMsk  <= '0;
      outMsk <= '0;
      epMsk  <= '0;
    end else begin
      if (strb.wrInMsk)  inMsk  <= wrData[STAT_W-1:0];
      if (strb.wrOutMsk) outMsk <= wrData[STAT_W-1:0];
      if (strb.wrEpMsk)  epMsk  <= wrData;
    end
  end

  // leaf status vectors: write-1-to-clear, a new event wins over a clear
  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic [STAT_W-1:0] inClr, outClr;
    assign inClr  = (strb.clrInSt  && epSel == EP_W'(g)) ? wrData[STAT_W-1:0] : '0;
    assign outClr = (strb.clrOutSt && epSel == EP_W'(g)) ? wrData[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        inSt[g]  <= '0;
        outSt[g] <= '0;
      end else begin
        inSt[g]  <= (inSt[g]  & ~inClr)  | inEvt[g*STAT_W +: STAT_W];
        outSt[g] <= (outSt[g] & ~outClr) | outEvt[g*STAT_W +: STAT_W];
      end
    end

    assign inEpSum[g]  = |(inSt[g]  & inMsk);
    assign outEpSum[g] = |(outSt[g] & outMsk);
  end

  always_comb begin
    allEp = '0;
    allEp[NUM_EP-1:0]        = inEpSum;
    allEp[OUT_BASE +: NUM_EP] = outEpSum;
  end

  assign inCore  = |(inEpSum  & epMsk[NUM_EP-1:0]);
  assign outCore = |(outEpSum & epMsk[OUT_BASE +: NUM_EP]);

  always_ff @(posedge clk) begin
    if (!rstN) intOut <= 1'b0;
    else       intOut <= inCore | outCore;
  end

  always_comb begin
    case (strb.rdSel)
      RD_IN_MSK:  rdData = DATA_W'(inMsk);
      RD_OUT_MSK: rdData = DATA_W'(outMsk);
      RD_ALL_EP:  rdData = allEp;
      RD_EP_MSK:  rdData = epMsk;
      RD_CORE:    rdData = DATA_W'({outCore, inCore});
      RD_IN_ST:   rdData = DATA_W'(inSt[epSel]);
      RD_OUT_ST:  rdData = DATA_W'(outSt[epSel]);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/epIrqAgg.sv
module epIrqAgg
  import epIrqPkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned STAT_W = 8,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_EP*STAT_W-1:0] inEvt,
  input  logic [NUM_EP*STAT_W-1:0] outEvt,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWrEn,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  output logic                     inIrq,
  output logic                     outIrq,
  output logic                     intOut
);

  ctrlStrobeT        strb;
  logic [EP_W-1:0]   epSel;
  logic [DATA_W-1:0] allEp;

  epIrqCtrl #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strb   (strb),
    .epSel  (epSel)
  );

  epIrqData #(.NUM_EP(NUM_EP), .STAT_W(STAT_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .epSel  (epSel),
    .wrData (regWrData),
    .inEvt  (inEvt),
    .outEvt (outEvt),
    .rdData (regRdData),
    .allEp  (allEp),
    .inCore (inIrq),
    .outCore(outIrq),
    .intOut (intOut)
  );

endmodule

// File: rtl/epIrqAggChk.sv
module epIrqAggChk
  import epIrqPkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned STAT_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_EP*STAT_W-1:0] inEvt,
  input logic [NUM_EP*STAT_W-1:0] outEvt,
  input logic [ADDR_W-1:0]        regAddr,
  input logic                     regWrEn,
  input logic [31:0]              allEp,
  input logic                     inIrq,
  input logic                     outIrq,
  input logic                     intOut
);

  logic maskWr;
  assign maskWr = regWrEn && (regAddr == ADDR_W'({REG_GLOBAL, OFS_IN_MSK}) ||
                              regAddr == ADDR_W'({REG_GLOBAL, OFS_OUT_MSK}));

  // R9
  int_out_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> intOut == $past(inIrq || outIrq));

  // R7
  in_core_needs_ep_chk: assert property (@(posedge clk) disable iff (!rstN)
    inIrq |-> |allEp[NUM_EP-1:0]);

  // R8
  out_core_needs_ep_chk: assert property (@(posedge clk) disable iff (!rstN)
    outIrq |-> |allEp[OUT_BASE +: NUM_EP]);

  // R2
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inEvt == '0 && outEvt == '0 && !maskWr) |=> ((allEp & ~$past(allEp)) == '0));

endmodule

bind epIrqAgg epIrqAggChk #(.NUM_EP(NUM_EP), .STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inEvt  (inEvt),
  .outEvt (outEvt),
  .regAddr(regAddr),
  .regWrEn(regWrEn),
  .allEp  (allEp),
  .inIrq  (inIrq),
  .outIrq (outIrq),
  .intOut (intOut)
);

// File: tb/test_epIrqAgg.sv
module test_epIrqAgg;

  localparam int NUM_EP = 16;
  localparam int STAT_W = 8;
  localparam int ADDR_W = 6;
  localparam int EVW    = NUM_EP * STAT_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic [EVW-1:0]    inEvt, outEvt;
  logic [ADDR_W-1:0] regAddr;
  logic              regWrEn;
  logic [31:0]       regWrData;
  logic [31:0]       regRdData;
  logic              inIrq, outIrq, intOut;

  always #4 clk = ~clk;

  epIrqAgg #(.NUM_EP(NUM_EP), .STAT_W(STAT_W), .ADDR_W(ADDR_W)) i_epIrqAgg (
    .clk(clk), .rstN(rstN), .inEvt(inEvt), .outEvt(outEvt),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .inIrq(inIrq), .outIrq(outIrq), .intOut(intOut)
  );

  // kind 0: read data, 1: intOut, 2: {outIrq, inIrq}
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } itemT;

  itemT queue[$];
  int   nChecks = 0;
  int   nFails  = 0;

  // monitor: samples mid low phase, after the driver has pushed
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (queue.size() > 0) begin
        itemT it;
        logic [31:0] act;
        it = queue.pop_front();
        case (it.kind)
          0:       act = regRdData;
          1:       act = {31'd0, intOut};
          default: act = {30'd0, outIrq, inIrq};
        endcase
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input logic [EVW-1:0] iv, input logic [EVW-1:0] ov);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; inEvt = iv; outEvt = ov;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    drive(1'b1, a, d, '0, '0);
  endtask

  task automatic evt(input logic [EVW-1:0] iv, input logic [EVW-1:0] ov);
    drive(1'b0, '0, '0, iv, ov);
  endtask

  task automatic chkRd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    drive(1'b0, a, '0, '0, '0);
    queue.push_back('{kind: 0, exp: e, tag: tag});
  endtask

  task automatic chkInt(input logic e, input string tag);
    drive(1'b0, '0, '0, '0, '0);
    queue.push_back('{kind: 1, exp: {31'd0, e}, tag: tag});
  endtask

  task automatic chkCore(input logic [1:0] e, input string tag);
    drive(1'b0, '0, '0, '0, '0);
    queue.push_back('{kind: 2, exp: {30'd0, e}, tag: tag});
  endtask

  function automatic logic [EVW-1:0] ev(input int ep, input logic [7:0] bits);
    logic [EVW-1:0] v = '0;
    v[ep*STAT_W +: STAT_W] = bits;
    return v;
  endfunction

  logic done = 1'b0;

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; inEvt = '0; outEvt = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkRd(6'h00, 32'h0, "R1 in mask");
    chkRd(6'h01, 32'h0, "R1 out mask");
    chkRd(6'h02, 32'h0, "R1 endpoint reg");
    chkRd(6'h03, 32'h0, "R1 ep mask");
    chkRd(6'h1F, 32'h0, "R1 in status ep15");
    chkCore(2'b00, "R1 core bits");
    chkInt(1'b0, "R1 intOut");

    // R2 event sets status, masked summary stays 0 (R5)
    evt(ev(3, 8'h05), '0);
    chkRd(6'h13, 32'h05, "R2 in status ep3");
    chkRd(6'h02, 32'h0, "R5 summary hidden by mask");

    // R5 mask enables selectively
    wr(6'h00, 32'h04);
    chkRd(6'h02, 32'h8, "R5 mask bit2 enables ep3");
    wr(6'h00, 32'h02);
    chkRd(6'h02, 32'h0, "R5 mask bit1 no match");
    wr(6'h00, 32'hFF);
    chkCore(2'b00, "R7 ep mask 0 blocks core");

    // R6 endpoint register ignores writes
    wr(6'h02, 32'hFFFF_FFFF);
    chkRd(6'h02, 32'h8, "R6 write ignored");

    // R8/R9 enable ep3 IN
    wr(6'h03, 32'h8);
    chkCore(2'b01, "R8 in core bit");
    queue.push_back('{kind: 1, exp: 32'h0, tag: "R9 intOut not yet"});
    chkInt(1'b1, "R9 intOut one cycle later");
    chkRd(6'h04, 32'h1, "R8 core read");

    // R6 bidirectional endpoint 5
    evt(ev(5, 8'h01), ev(5, 8'h80));
    chkRd(6'h25, 32'h80, "R2 out status ep5");
    chkRd(6'h02, 32'h28, "R5 out mask still 0");
    wr(6'h01, 32'h80);
    chkRd(6'h02, 32'h0020_0028, "R6 bidirectional layout");

    // R7 masked endpoint remains visible
    wr(6'h03, 32'h0020_0000);
    chkRd(6'h04, 32'h2, "R7 only out core");
    chkRd(6'h02, 32'h0020_0028, "R7 masked eps visible");

    // R3 write-1-to-clear
    wr(6'h13, 32'h01);
    chkRd(6'h13, 32'h04, "R3 clear bit0 only");
    chkRd(6'h02, 32'h0020_0028, "R3 summary kept");
    wr(6'h15, 32'hFE);
    chkRd(6'h15, 32'h01, "R3 zero bits untouched");

    // R4 event wins over clear
    drive(1'b1, 6'h13, 32'h05, ev(3, 8'h01), '0);
    chkRd(6'h13, 32'h01, "R4 event beats clear");

    // R10 clearing leaves propagates upward
    wr(6'h13, 32'hFF);
    chkRd(6'h02, 32'h0020_0020, "R10 ep3 bit dropped");
    chkInt(1'b1, "R10 intOut before clear");
    wr(6'h25, 32'h80);
    chkCore(2'b00, "R10 core drops same cycle");
    queue.push_back('{kind: 1, exp: 32'h1, tag: "R10 intOut lags"});
    chkInt(1'b0, "R10 intOut drops");
    chkRd(6'h02, 32'h20, "R10 endpoint reg");

    // R5 shared mask applies to every endpoint, edge endpoints
    evt(ev(0, 8'h02), ev(15, 8'h08));
    chkRd(6'h2F, 32'h08, "R2 out status ep15");
    chkRd(6'h02, 32'h21, "R5 shared masks ep0 and ep15");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule